// File: doc/BRIEF.md
# Serial Codec Mode-Change Controller

This block sits on the receive side of a time-division serial codec port. It takes control words that have already been parsed, each 16 bits wide and tagged with its slot number, together with a frame-sync strobe. It keeps track of the mode-change-enable state. While that state is on, it collects writes to the frame-size, two-wire slot-select and autocalibration-enable bits. It stores each write in a shadow register and moves the shadow registers into the live configuration only at the next frame sync.

When a control word ends the mode-change-enable state, the block checks the live autocalibration-enable bit. If the bit is set, it issues a one-cycle calibration request. It then holds a busy flag for a fixed number of frames. A not-ready flag stays high from reset until the first calibration completes. When autocalibration is disabled, leaving the enable state starts nothing and the existing calibration state is kept.

Top module: `codec_mode_ctrl`

## Requirements
- R1: After synchronous reset the outputs are as follows: frame-size, slot-select and calibration-enable are 0, `mce_active` is 1, `not_ready` is 1, and `cal_busy` and `cal_req` are 0.
- R2: The control word layout is fixed. Bit 15 is the mode-change-enable flag and bits 11:8 are the register index. Index 4'b1100 writes `cfg_frs` from bit 7 (1 = 16 slots per frame, 0 = 32 slots per frame) and `cfg_tssel` from bit 6. Index 4'b1001 writes `cfg_acal` from bit 3.
- R3: A write is staged and reaches the configuration outputs on the first frame sync sampled after the word. The configuration outputs change on no other clock edge.
- R4: A word is accepted in slot 0 at all times. A word in slot 16 is accepted only while `cfg_frs` is 0. Words in any other slot have no effect.
- R5: An accepted word whose bit 15 is 0 stages no register write.
- R6: An accepted word with bit 15 at 0 while `mce_active` is 1 is an exit. If `cfg_acal` is 1 and the block is not busy, an exit raises `cal_req` for exactly one cycle on the edge that accepts the word, and `cal_busy` rises on the same edge.
- R7: An exit while `cfg_acal` is 0 raises no request and leaves `cal_busy` and `not_ready` unchanged.
- R8: `cal_busy` stays high until the CAL_FRAMES-th frame sync after the request. It falls on that edge, and `not_ready` falls on the same edge.
- R9: An exit that occurs while `cal_busy` is high starts no second request.
- R10: In 32-slot mode, a slot-16 word with bit 15 at 0 counts as an exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | A parsed control word is present this cycle |
| word_slot | input | SLOT_W | Slot number of the word |
| word_data | input | 16 | Control word |
| frame_sync | input | 1 | One-cycle frame boundary strobe |
| cfg_frs | output | 1 | Live frame-size bit (1 = 16 slots) |
| cfg_tssel | output | 1 | Live two-wire slot-select bit |
| cfg_acal | output | 1 | Live autocalibration-enable bit |
| mce_active | output | 1 | Mode-change-enable state |
| cal_req | output | 1 | One-cycle calibration request |
| cal_busy | output | 1 | Calibration in progress |
| not_ready | output | 1 | No completed calibration since reset |

## Verification
Every output is a register, so a result that a word or sync causes is due on the clock edge that samples that word or sync. `mce_active`, `cal_req` and `cal_busy` update on the edge that accepts the word. The configuration bits update on the edge that samples the next frame sync. `cal_busy` and `not_ready` fall on the edge of the CAL_FRAMES-th sync. The bench drives inputs on the falling edge and holds each strobe for one rising edge. It samples 1 ns after that edge, so each check sees the first cycle in which the result is due. It checks that a staged write has not yet appeared before it sends the sync, and it samples `cal_req` again one cycle later to confirm the pulse lasts one cycle.

// File: rtl/codec_mode_pkg.sv
package codec_mode_pkg;
  localparam int WORD_W      = 16;
  localparam int MCE_POS     = 15;
  localparam int IDX_HI      = 11;
  localparam int IDX_LO      = 8;
  localparam logic [3:0] IDX_MISC = 4'b1100;
  localparam logic [3:0] IDX_IFC  = 4'b1001;
  localparam int FRS_POS     = 7;
  localparam int TSSEL_POS   = 6;
  localparam int ACAL_POS    = 3;

  typedef struct packed {
    logic frs;
    logic tssel;
    logic acal;
  } mode_cfg_t;
endpackage

// File: rtl/cmc_word_decode.sv
module cmc_word_decode
  import codec_mode_pkg::*;
#(
  parameter int SLOT_W      = 5,
  parameter int SECOND_SLOT = 16
) (
  input  logic              word_valid,
  input  logic [SLOT_W-1:0] word_slot,
  input  logic [WORD_W-1:0] word_data,
  input  logic              frs_live,
  output logic              accept,
  output logic              mce_bit,
  output logic              misc_wr,
  output logic              ifc_wr,
  output logic              frs_bit,
  output logic              tssel_bit,
  output logic              acal_bit
);
  logic [3:0] idx;
  logic       slot_ok;
  logic       unused_bits;

  assign idx     = word_data[IDX_HI:IDX_LO];
  assign slot_ok = (word_slot == '0) ||
                   (!frs_live && word_slot == SLOT_W'(SECOND_SLOT));
  assign accept  = word_valid && slot_ok;
  assign mce_bit = word_data[MCE_POS];
  assign misc_wr = accept && mce_bit && (idx == IDX_MISC);
  assign ifc_wr  = accept && mce_bit && (idx == IDX_IFC);
  assign frs_bit   = word_data[FRS_POS];
  assign tssel_bit = word_data[TSSEL_POS];
  assign acal_bit  = word_data[ACAL_POS];
  assign unused_bits = ^{word_data[14:12], word_data[5:4], word_data[2:0]};
endmodule

// File: rtl/cmc_config_stage.sv
module cmc_config_stage
  import codec_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      misc_wr,
  input  logic      ifc_wr,
  input  logic      frs_bit,
  input  logic      tssel_bit,
  input  logic      acal_bit,
  input  logic      frame_sync,
  output mode_cfg_t live
);
  mode_cfg_t shadow;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      live   <= '0;
    end else begin
      if (frame_sync) live <= shadow;
      if (misc_wr) begin
        shadow.frs   <= frs_bit;
        shadow.tssel <= tssel_bit;
      end
      if (ifc_wr) shadow.acal <= acal_bit;
    end
  end
endmodule

// File: rtl/cmc_cal_seq.sv
module cmc_cal_seq #(
  parameter int CAL_FRAMES = 4,
  localparam int CNT_W = $clog2(CAL_FRAMES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic mce_bit,
  input  logic acal_live,
  input  logic frame_sync,
  output logic mce_active,
  output logic cal_req,
  output logic cal_busy,
  output logic not_ready
);
  logic [CNT_W-1:0] frame_cnt;
  logic             exit_evt;

  assign exit_evt = accept && !mce_bit && mce_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      mce_active <= 1'b1;
      cal_req    <= 1'b0;
      cal_busy   <= 1'b0;
      not_ready  <= 1'b1;
      frame_cnt  <= '0;
    end else begin
      cal_req <= 1'b0;
      if (accept) mce_active <= mce_bit;
      if (cal_busy) begin
        if (frame_sync) begin
          if (frame_cnt == CNT_W'(CAL_FRAMES - 1)) begin
            cal_busy  <= 1'b0;
            not_ready <= 1'b0;
            frame_cnt <= '0;
          end else begin
            frame_cnt <= frame_cnt + 1'b1;
          end
        end
      end else if (exit_evt && acal_live) begin
        cal_req   <= 1'b1;
        cal_busy  <= 1'b1;
        frame_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/codec_mode_ctrl.sv
module codec_mode_ctrl
  import codec_mode_pkg::*;
#(
  parameter int SLOT_W      = 5,
  parameter int SECOND_SLOT = 16,
  parameter int CAL_FRAMES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [SLOT_W-1:0] word_slot,
  input  logic [15:0]       word_data,
  input  logic              frame_sync,
  output logic              cfg_frs,
  output logic              cfg_tssel,
  output logic              cfg_acal,
  output logic              mce_active,
  output logic              cal_req,
  output logic              cal_busy,
  output logic              not_ready
);
  mode_cfg_t live;
  logic accept, mce_bit, misc_wr, ifc_wr, frs_bit, tssel_bit, acal_bit;

  cmc_word_decode #(.SLOT_W(SLOT_W), .SECOND_SLOT(SECOND_SLOT)) dec_i (
    .word_valid(word_valid), .word_slot(word_slot), .word_data(word_data),
    .frs_live(live.frs), .accept(accept), .mce_bit(mce_bit),
    .misc_wr(misc_wr), .ifc_wr(ifc_wr), .frs_bit(frs_bit),
    .tssel_bit(tssel_bit), .acal_bit(acal_bit)
  );

  cmc_config_stage cfg_i (
    .clk(clk), .rst(rst), .misc_wr(misc_wr), .ifc_wr(ifc_wr),
    .frs_bit(frs_bit), .tssel_bit(tssel_bit), .acal_bit(acal_bit),
    .frame_sync(frame_sync), .live(live)
  );

  cmc_cal_seq #(.CAL_FRAMES(CAL_FRAMES)) cal_i (
    .clk(clk), .rst(rst), .accept(accept), .mce_bit(mce_bit),
    .acal_live(live.acal), .frame_sync(frame_sync),
    .mce_active(mce_active), .cal_req(cal_req), .cal_busy(cal_busy),
    .not_ready(not_ready)
  );

  assign cfg_frs   = live.frs;
  assign cfg_tssel = live.tssel;
  assign cfg_acal  = live.acal;
endmodule

// File: rtl/codec_mode_ctrl_chk.sv
module codec_mode_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic frame_sync,
  input logic cfg_frs,
  input logic cfg_tssel,
  input logic cfg_acal,
  input logic mce_active,
  input logic cal_req,
  input logic cal_busy,
  input logic not_ready
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (mce_active && not_ready && !cal_busy && !cal_req && !cfg_frs));

  a_r3_cfg_only_on_sync: assert property (@(posedge clk) disable iff (rst)
    !frame_sync |=> ($stable(cfg_frs) && $stable(cfg_tssel) && $stable(cfg_acal)));

  a_r6_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
    cal_req |=> !cal_req);

  a_r6_req_sets_busy: assert property (@(posedge clk) disable iff (rst)
    cal_req |-> cal_busy);

  a_r8_ready_at_busy_end: assert property (@(posedge clk) disable iff (rst)
    $fell(not_ready) |-> $fell(cal_busy));

  a_r9_no_retrigger: assert property (@(posedge clk) disable iff (rst)
    (cal_busy && $past(cal_busy)) |-> !cal_req);
endmodule

bind codec_mode_ctrl codec_mode_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .frame_sync(frame_sync), .cfg_frs(cfg_frs),
  .cfg_tssel(cfg_tssel), .cfg_acal(cfg_acal), .mce_active(mce_active),
  .cal_req(cal_req), .cal_busy(cal_busy), .not_ready(not_ready)
);

// File: tb/codec_mode_ctrl_tb.sv
module codec_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT_W     = 5;
  localparam int CAL_FRAMES = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_valid = 1'b0;
  logic [SLOT_W-1:0] word_slot = '0;
  logic [15:0] word_data = '0;
  logic frame_sync = 1'b0;
  logic cfg_frs, cfg_tssel, cfg_acal, mce_active, cal_req, cal_busy, not_ready;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  codec_mode_ctrl #(.SLOT_W(SLOT_W), .CAL_FRAMES(CAL_FRAMES)) dut_i (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_slot(word_slot),
    .word_data(word_data), .frame_sync(frame_sync), .cfg_frs(cfg_frs),
    .cfg_tssel(cfg_tssel), .cfg_acal(cfg_acal), .mce_active(mce_active),
    .cal_req(cal_req), .cal_busy(cal_busy), .not_ready(not_ready)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic mce, input logic [3:0] idx, input logic [7:0] dat);
    return {mce, 3'b000, idx, dat};
  endfunction

  task automatic send_word(input logic [SLOT_W-1:0] slot, input logic [15:0] w);
    @(negedge clk);
    word_valid = 1'b1; word_slot = slot; word_data = w;
    @(posedge clk); #1;
    word_valid = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    frame_sync = 1'b1;
    @(posedge clk); #1;
    frame_sync = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "cfg_frs", cfg_frs, 1'b0);
    chk("R1", "cfg_tssel", cfg_tssel, 1'b0);
    chk("R1", "cfg_acal", cfg_acal, 1'b0);
    chk("R1", "mce_active", mce_active, 1'b1);
    chk("R1", "not_ready", not_ready, 1'b1);
    chk("R1", "cal_busy", cal_busy, 1'b0);
    chk("R1", "cal_req", cal_req, 1'b0);
  endtask

  task automatic t_stage();
    send_word(0, mk(1'b1, 4'b1100, 8'hC0));
    chk("R3", "frs before sync", cfg_frs, 1'b0);
    repeat (3) @(posedge clk);
    #1 chk("R3", "tssel before sync", cfg_tssel, 1'b0);
    pulse_sync();
    chk("R2", "frs after sync", cfg_frs, 1'b1);
    chk("R2", "tssel after sync", cfg_tssel, 1'b1);
  endtask

  task automatic t_slot_filter();
    send_word(16, mk(1'b1, 4'b1100, 8'h00));
    send_word(5, mk(1'b1, 4'b1100, 8'h00));
    pulse_sync();
    chk("R4", "slot16/5 ignored in 16-slot mode", cfg_frs, 1'b1);
    send_word(0, mk(1'b1, 4'b1100, 8'h00));
    pulse_sync();
    chk("R4", "slot0 write frs=0", cfg_frs, 1'b0);
    send_word(16, mk(1'b1, 4'b1100, 8'h40));
    pulse_sync();
    chk("R4", "slot16 accepted in 32-slot mode", cfg_tssel, 1'b1);
  endtask

  task automatic t_no_mce();
    send_word(0, mk(1'b0, 4'b1100, 8'h80));
    chk("R7", "no req when acal=0", cal_req, 1'b0);
    chk("R7", "busy stays low", cal_busy, 1'b0);
    chk("R7", "mce left", mce_active, 1'b0);
    pulse_sync();
    chk("R5", "write with mce=0 not staged", cfg_frs, 1'b0);
    chk("R7", "not_ready kept", not_ready, 1'b1);
  endtask

  task automatic t_cal();
    send_word(0, mk(1'b1, 4'b1001, 8'h08));
    pulse_sync();
    chk("R2", "acal live", cfg_acal, 1'b1);
    send_word(16, mk(1'b0, 4'b0000, 8'h00));
    chk("R10", "slot16 exit raises req", cal_req, 1'b1);
    chk("R6", "busy with req", cal_busy, 1'b1);
    @(posedge clk); #1;
    chk("R6", "req one cycle", cal_req, 1'b0);
    send_word(0, mk(1'b1, 4'b0000, 8'h00));
    send_word(0, mk(1'b0, 4'b0000, 8'h00));
    chk("R9", "no req while busy", cal_req, 1'b0);
    for (int i = 0; i < CAL_FRAMES - 1; i++) pulse_sync();
    chk("R8", "busy before last sync", cal_busy, 1'b1);
    chk("R8", "not_ready before last sync", not_ready, 1'b1);
    pulse_sync();
    chk("R8", "busy cleared", cal_busy, 1'b0);
    chk("R8", "ready after cal", not_ready, 1'b0);
    chk("R9", "no late req", cal_req, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_stage();
    t_slot_filter();
    t_no_mce();
    t_cal();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule